// File: doc/BRIEF.md
# Serial Flash Burst Read Controller

This block reads a run of consecutive bytes out of a serial flash memory over a four-wire SPI bus. A host places a 24-bit start address and a byte count on its inputs and pulses `start` while `ready` is high. The controller pulls chip select low and sends the read command byte and then the three address bytes. It then keeps the serial clock running for as many bytes as were requested. Each byte it collects is handed to the host on `rd_data` with a one-cycle `rd_valid` strobe. When the last byte is in, it parks the clock low and releases chip select.

The serial clock comes from the system clock. Its high and low phases each last `half_period` system clocks, and a value of zero counts as one. The master changes its outgoing bit only while the serial clock is low. It samples the incoming line at each rising edge of the serial clock, so the memory is expected to shift its bit on the falling edge.

The sequence is kept by a five-state controller:
- `ST_IDLE`: waits for `start`. A nonzero count moves it to `ST_OPCODE`. A zero count leaves it where it is.
- `ST_OPCODE`: shifts out the command byte. When that byte completes it moves to `ST_ADDR`.
- `ST_ADDR`: shifts out the three address bytes. After the third it moves to `ST_DATA`.
- `ST_DATA`: receives bytes. After the last one it moves to `ST_TRAIL`.
- `ST_TRAIL`: holds the clock low for one half period and then returns to `ST_IDLE`.

Top module: `sflash_rd_master`

## Requirements
- R1: `spi_sck` is 0 whenever `spi_cs_n` is 1, and it is already 0 before `spi_cs_n` rises at the end of a frame.
- R2: `spi_mosi` changes only while `spi_sck` is low, so it is stable at every rising edge. `spi_miso` is sampled at each rising edge of `spi_sck`.
- R3: Every byte on the bus, in either direction, goes most significant bit first (bit 7 first).
- R4: `spi_cs_n` falls before the first rising edge of `spi_sck` and stays low for the whole frame. A frame with a byte count N carries exactly 8*(4+N) rising edges of `spi_sck`.
- R5: The first byte sent is 0x03. It is followed by address bits 23:16, then 15:8, then 7:0.
- R6: Exactly N bytes are delivered, in bus order. Each byte appears on `rd_data` while `rd_valid` is high, and `rd_valid` is high for exactly one system clock per byte.
- R7: Each high phase of `spi_sck` lasts `half_period` system clocks. A `half_period` of 0 behaves as 1.
- R8: `ready` is 1 only while idle. A `start` pulse while busy is ignored: it does not change the running frame and does not cause a second frame.
- R9: A `start` with a byte count of 0 leaves `spi_cs_n` high, and `ready` is 1 on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a read (accepted only when `ready`) |
| start_addr | input | ADDR_W | First byte address |
| byte_count | input | CNT_W | Number of bytes to read |
| half_period | input | DIV_W | System clocks per SCK phase (0 treated as 1) |
| ready | output | 1 | High while idle |
| rd_data | output | 8 | Received byte |
| rd_valid | output | 1 | One-cycle strobe for `rd_data` |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to memory |
| spi_miso | input | 1 | Serial data from memory |

## Verification
The bench builds the block with `CNT_W` = 8 and keeps the default 24-bit address and 8-bit divider. That lets a 255-byte burst run, so the largest count is reached and the slave's address counter wraps past 0xFFFFFF, while the run stays short. At run time `half_period` is set to 0, 1 and 3, which covers the clamp at zero and a multi-cycle phase. A behavioural memory on the bus decodes the command and address and returns bytes computed from their addresses.

// File: rtl/sflash_pkg.sv
package sflash_pkg;
    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] READ_OPCODE = 8'h03;
    localparam logic [BYTE_W-1:0] FILL_BYTE   = 8'h00;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_ADDR,
        ST_DATA,
        ST_TRAIL
    } rd_state_t;
endpackage

// File: rtl/sflash_sck_gen.sv
module sflash_sck_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             hold,
    input  logic [DIV_W-1:0] half_period,
    output logic             sck,
    output logic             tick,
    output logic             rise_tick,
    output logic             fall_tick
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] limit;

    // A zero setting is clamped to one system clock per phase.
    always_comb begin
        limit     = (half_period == '0) ? DIV_W'(1) : half_period;
        tick      = run && (cnt_q == limit - DIV_W'(1));
        rise_tick = tick && !hold && !sck;
        fall_tick = tick && !hold && sck;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sck   <= 1'b0;
        end else if (!run) begin
            cnt_q <= '0;
            sck   <= 1'b0;
        end else if (tick) begin
            cnt_q <= '0;
            if (!hold) begin
                sck <= ~sck;
            end
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end

    // A phase never ends before it has lasted at least one full count.
    p_phase_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && !$past(tick) && $past(cnt_q) < $past(limit) - DIV_W'(1))
            |-> $stable(sck));
endmodule

// File: rtl/sflash_byte_shifter.sv
module sflash_byte_shifter
    import sflash_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_byte,
    input  logic              rise_tick,
    input  logic              fall_tick,
    input  logic              miso,
    output logic              mosi,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              byte_done
);
    localparam int BIT_W = $clog2(BYTE_W);

    logic [BYTE_W-1:0] tx_q;
    logic [BYTE_W-1:0] rx_q;
    logic [BIT_W-1:0]  bit_q;

    // Most significant bit leaves first; the last fall of a byte ends it.
    assign mosi      = tx_q[BYTE_W-1];
    assign rx_byte   = rx_q;
    assign byte_done = fall_tick && (bit_q == BIT_W'(BYTE_W - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q  <= '0;
            rx_q  <= '0;
            bit_q <= '0;
        end else begin
            if (rise_tick) begin
                rx_q <= {rx_q[BYTE_W-2:0], miso};
            end
            if (load) begin
                tx_q  <= load_byte;
                bit_q <= '0;
            end else if (fall_tick) begin
                tx_q  <= {tx_q[BYTE_W-2:0], 1'b0};
                bit_q <= bit_q + BIT_W'(1);
            end
        end
    end

    // The outgoing bit is held across every rising clock edge.
    p_tx_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rise_tick) |-> $stable(mosi));
endmodule

// File: rtl/sflash_rd_fsm.sv
module sflash_rd_fsm
    import sflash_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [CNT_W-1:0]  byte_count,
    input  logic              tick,
    input  logic              byte_done,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic              ready,
    output logic              cs_n,
    output logic              run,
    output logic              hold,
    output logic              load,
    output logic [BYTE_W-1:0] load_byte,
    output logic [BYTE_W-1:0] rd_data,
    output logic              rd_valid
);
    localparam int ADDR_BYTES = ADDR_W / BYTE_W;
    localparam int AIDX_W     = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
    localparam logic [AIDX_W-1:0] LAST_AIDX = AIDX_W'(ADDR_BYTES - 1);

    rd_state_t         state_q, state_d;
    logic [ADDR_W-1:0] addr_q, addr_d;
    logic [CNT_W-1:0]  remain_q, remain_d;
    logic [AIDX_W-1:0] aidx_q, aidx_d;
    logic [BYTE_W-1:0] data_q, data_d;
    logic              valid_q, valid_d;

    // Address bytes are taken from the top of the address downwards.
    function automatic logic [BYTE_W-1:0] addr_byte(input logic [ADDR_W-1:0] a,
                                                    input logic [AIDX_W-1:0] idx);
        logic [ADDR_W-1:0] sh;
        sh = a << (BYTE_W * int'(idx));
        return sh[ADDR_W-1 -: BYTE_W];
    endfunction

    // State register process.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            addr_q   <= '0;
            remain_q <= '0;
            aidx_q   <= '0;
            data_q   <= '0;
            valid_q  <= 1'b0;
        end else begin
            state_q  <= state_d;
            addr_q   <= addr_d;
            remain_q <= remain_d;
            aidx_q   <= aidx_d;
            data_q   <= data_d;
            valid_q  <= valid_d;
        end
    end

    // Transitions and byte loading.
    always_comb begin
        state_d   = state_q;
        addr_d    = addr_q;
        remain_d  = remain_q;
        aidx_d    = aidx_q;
        data_d    = data_q;
        valid_d   = 1'b0;
        load      = 1'b0;
        load_byte = FILL_BYTE;
        unique case (state_q)
            ST_IDLE: begin
                if (start && byte_count != '0) begin
                    addr_d    = start_addr;
                    remain_d  = byte_count;
                    aidx_d    = '0;
                    load      = 1'b1;
                    load_byte = READ_OPCODE;
                    state_d   = ST_OPCODE;
                end
            end
            ST_OPCODE: begin
                if (byte_done) begin
                    load      = 1'b1;
                    load_byte = addr_byte(addr_q, '0);
                    aidx_d    = '0;
                    state_d   = ST_ADDR;
                end
            end
            ST_ADDR: begin
                if (byte_done) begin
                    load = 1'b1;
                    if (aidx_q == LAST_AIDX) begin
                        load_byte = FILL_BYTE;
                        state_d   = ST_DATA;
                    end else begin
                        load_byte = addr_byte(addr_q, aidx_q + AIDX_W'(1));
                        aidx_d    = aidx_q + AIDX_W'(1);
                    end
                end
            end
            ST_DATA: begin
                if (byte_done) begin
                    data_d   = rx_byte;
                    valid_d  = 1'b1;
                    remain_d = remain_q - CNT_W'(1);
                    if (remain_q == CNT_W'(1)) begin
                        state_d = ST_TRAIL;
                    end else begin
                        load      = 1'b1;
                        load_byte = FILL_BYTE;
                    end
                end
            end
            ST_TRAIL: begin
                if (tick) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Output process.
    always_comb begin
        ready    = (state_q == ST_IDLE);
        cs_n     = (state_q == ST_IDLE);
        run      = (state_q != ST_IDLE);
        hold     = (state_q == ST_TRAIL);
        rd_data  = data_q;
        rd_valid = valid_q;
    end

    p_busy_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && start) |=> $stable(addr_q));

    p_zero_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && start && byte_count == '0) |=> (ready && cs_n));

    p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);
endmodule

// File: rtl/sflash_rd_master.sv
module sflash_rd_master
    import sflash_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 16,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [CNT_W-1:0]  byte_count,
    input  logic [DIV_W-1:0]  half_period,
    output logic              ready,
    output logic [BYTE_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              spi_sck,
    output logic              spi_cs_n,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    logic              run, hold, tick, rise_tick, fall_tick;
    logic              load, byte_done;
    logic [BYTE_W-1:0] load_byte, rx_byte;

    sflash_sck_gen #(.DIV_W(DIV_W)) u_sck (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (run),
        .hold        (hold),
        .half_period (half_period),
        .sck         (spi_sck),
        .tick        (tick),
        .rise_tick   (rise_tick),
        .fall_tick   (fall_tick)
    );

    sflash_byte_shifter u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_byte (load_byte),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .miso      (spi_miso),
        .mosi      (spi_mosi),
        .rx_byte   (rx_byte),
        .byte_done (byte_done)
    );

    sflash_rd_fsm #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_addr (start_addr),
        .byte_count (byte_count),
        .tick       (tick),
        .byte_done  (byte_done),
        .rx_byte    (rx_byte),
        .ready      (ready),
        .cs_n       (spi_cs_n),
        .run        (run),
        .hold       (hold),
        .load       (load),
        .load_byte  (load_byte),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid)
    );

    p_sck_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck);

    p_mosi_setup_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_sck) |-> $stable(spi_mosi));

    p_frame_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_cs_n) |-> $past(!spi_sck));

    p_ready_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (spi_cs_n && !spi_sck));
endmodule

// File: tb/sflash_rd_master_bench.sv
module sflash_rd_master_bench;
    localparam int ADDR_W = 24;
    localparam int CNT_W  = 8;
    localparam int DIV_W  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [ADDR_W-1:0] start_addr = '0;
    logic [CNT_W-1:0]  byte_count = '0;
    logic [DIV_W-1:0]  half_period = DIV_W'(1);
    logic              ready, rd_valid, spi_sck, spi_cs_n, spi_mosi;
    logic              spi_miso = 1'b0;
    logic [7:0]        rd_data;

    always #5 clk = ~clk;

    sflash_rd_master #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DIV_W(DIV_W)) u_sflash_rd_master (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .byte_count(byte_count), .half_period(half_period), .ready(ready),
        .rd_data(rd_data), .rd_valid(rd_valid), .spi_sck(spi_sck),
        .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    int n_checks = 0;
    int n_fail   = 0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] mem_byte(input logic [23:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ a[23:16] ^ 8'h5C;
    endfunction

    // Behavioural memory on the bus.
    int          s_bits = 0;
    logic [31:0] s_hdr = '0;
    int          frames = 0;
    int          rises = 0;
    int          proto_err = 0;

    always @(negedge spi_cs_n) begin
        frames++;
        s_bits = 0;
        s_hdr  = '0;
    end
    always @(posedge spi_sck) begin
        if (spi_cs_n) proto_err++;
        rises++;
        if (s_bits < 32) s_hdr = {s_hdr[30:0], spi_mosi};
        s_bits++;
    end
    always @(negedge spi_sck) begin
        if (!spi_cs_n && s_bits >= 32) begin
            automatic int k = s_bits - 32;
            automatic logic [7:0] b = mem_byte(s_hdr[23:0] + 24'(k / 8));
            spi_miso <= b[7 - (k % 8)];
        end
    end
    always @(posedge spi_cs_n) begin
        if (spi_sck) proto_err++;
    end

    // Host-side monitor and clock-width measurement.
    logic [23:0] exp_base = '0;
    int          got = 0;
    int          data_err = 0;
    logic        prev_v = 1'b0;
    logic        sck_last = 1'b0;
    int          run_len = 0;
    int          hi_min = 1000;
    int          hi_max = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (rd_valid) begin
                if (prev_v) data_err++;
                if (rd_data !== mem_byte(exp_base + 24'(got))) data_err++;
                got++;
            end
            prev_v = rd_valid;
            if (spi_sck != sck_last) begin
                if (sck_last) begin
                    if (run_len < hi_min) hi_min = run_len;
                    if (run_len > hi_max) hi_max = run_len;
                end
                run_len = 1;
            end else begin
                run_len++;
            end
            sck_last = spi_sck;
        end
    end

    bit timed_out = 1'b0;

    task automatic wait_ready();
        for (int i = 0; i < 40000; i++) begin
            @(negedge clk);
            if (ready) return;
        end
        timed_out = 1'b1;
    endtask

    task automatic pulse_start(input logic [23:0] a, input int n);
        @(negedge clk);
        start_addr = a;
        byte_count = CNT_W'(n);
        start      = 1'b1;
        @(negedge clk);
        start      = 1'b0;
    endtask

    task automatic run_read(input logic [23:0] a, input int n, input int hp, input string tag);
        int f0, r0;
        half_period = DIV_W'(hp);
        f0 = frames; r0 = rises;
        got = 0; data_err = 0; proto_err = 0; hi_min = 1000; hi_max = 0;
        exp_base = a;
        pulse_start(a, n);
        check(!ready, {tag, " R8 busy"}, ready, 0);
        wait_ready();
        @(negedge clk);
        check(frames - f0 == 1, {tag, " R4 frames"}, frames - f0, 1);
        check(rises - r0 == 8 * (4 + n), {tag, " R4 sck pulses"}, rises - r0, 8 * (4 + n));
        check(s_hdr[31:24] == 8'h03, {tag, " R5 opcode"}, s_hdr[31:24], 3);
        check(s_hdr[23:0] == a, {tag, " R5 R3 address"}, s_hdr[23:0], a);
        check(got == n, {tag, " R6 byte count"}, got, n);
        check(data_err == 0, {tag, " R6 R3 data"}, data_err, 0);
        check(proto_err == 0, {tag, " R1 R4 framing"}, proto_err, 0);
        check(spi_cs_n && !spi_sck, {tag, " R1 idle bus"}, {spi_cs_n, spi_sck}, 2);
    endtask

    task automatic t_reset_state();
        check(ready == 1'b1, "R8 reset ready", ready, 1);
        check(spi_cs_n == 1'b1, "R4 reset cs_n", spi_cs_n, 1);
        check(spi_sck == 1'b0, "R1 reset sck", spi_sck, 0);
        check(rd_valid == 1'b0, "R6 reset valid", rd_valid, 0);
    endtask

    task automatic t_basic_read();
        run_read(24'h123456, 4, 1, "basic");
        check(hi_min == 1 && hi_max == 1, "R7 hp=1 width", hi_max, 1);
    endtask

    task automatic t_msb_pattern();
        run_read(24'h80_01_7F, 3, 2, "msb");
        check(hi_min == 2 && hi_max == 2, "R7 hp=2 width", hi_max, 2);
    endtask

    task automatic t_divider();
        run_read(24'h00A0C3, 2, 3, "div3");
        check(hi_min == 3 && hi_max == 3, "R7 hp=3 width", hi_max, 3);
        run_read(24'hFF00FF, 2, 0, "div0");
        check(hi_min == 1 && hi_max == 1, "R7 hp=0 clamp", hi_max, 1);
    endtask

    task automatic t_zero_count();
        int f0;
        f0 = frames;
        pulse_start(24'h000100, 0);
        check(ready == 1'b1, "R9 ready after zero", ready, 1);
        repeat (10) @(negedge clk);
        check(frames == f0, "R9 no frame", frames - f0, 0);
        check(spi_cs_n == 1'b1, "R9 cs_n high", spi_cs_n, 1);
    endtask

    task automatic t_busy_start();
        int f0;
        f0 = frames;
        half_period = DIV_W'(1);
        got = 0; data_err = 0;
        exp_base = 24'h0C0DE0;
        pulse_start(24'h0C0DE0, 2);
        repeat (20) @(negedge clk);
        start_addr = 24'h777777;
        byte_count = CNT_W'(5);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_ready();
        @(negedge clk);
        check(frames - f0 == 1, "R8 single frame", frames - f0, 1);
        check(s_hdr[23:0] == 24'h0C0DE0, "R8 address kept", s_hdr[23:0], 24'h0C0DE0);
        check(got == 2, "R8 count kept", got, 2);
        check(data_err == 0, "R8 data kept", data_err, 0);
    endtask

    task automatic t_long_burst();
        run_read(24'hFFFFF0, 255, 1, "long");
    endtask

    initial begin
        #1_500_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_basic_read();
        t_msb_pattern();
        t_divider();
        t_zero_count();
        t_busy_start();
        t_long_burst();
        if (timed_out) begin
            n_fail++;
            $display("FAIL R8 ready timeout: actual 0 expected 1");
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule